// File: doc/BRIEF.md
# Protected Clock Prescaler Controller

This block holds the main clock configuration registers of a chip and turns the prescaler setting into a clock-enable pulse. Software reaches it over a byte-wide register bus with an address, write data, a write strobe, a read strobe and read data. A separate protection unit drives an `unlock` level, and configuration writes are accepted only while that level is high.

The prescaler register holds an enable bit and a 4-bit divisor code. These select a divide ratio from a mixed set: powers of two from 2 to 64, plus 6, 10, 12, 24 and 48. A free-running divider then raises `tick` for one cycle out of every N base clocks. Logic that runs at the reduced rate uses `tick` as its clock enable.

Top module: `clk_prescale_regs`

## Requirements
- R1: A write to offset 0x00, 0x01 or 0x08 made while `unlock` is low leaves that register, its read value and the tick period unchanged.
- R2: A write to offset 0x00 (control), 0x01 (prescaler) or 0x08 (oscillator control) made while `unlock` is high stores all 8 bits, and a later read of that offset returns them.
- R3: In the prescaler register, bit 0 is the enable and bits 4:1 are the divisor code, and bits 7:5 have no effect on the ratio. With bit 0 clear, `tick` is high on every cycle.
- R4: With the enable set, codes 0, 1, 2, 3, 4 and 5 give a tick period of 2, 4, 8, 16, 32 and 64 cycles.
- R5: With the enable set, codes 8, 9, 10, 11 and 12 give a tick period of 6, 10, 12, 24 and 48 cycles.
- R6: With the enable set, the reserved codes 6, 7, 13, 14 and 15 give a tick period of 2.
- R7: The status register at offset 0x02 ignores bus writes, and its bit 0 (oscillator changing) always reads 0. An accepted prescaler write clears that flag.
- R8: When the ratio changes, the divider restarts. `tick` is high in the second cycle after the accepting clock edge, and then every N cycles.
- R9: After reset every register reads 0x00 and `tick` is high on every cycle.
- R10: `rdata` is 0x00 while `rd_en` is low and for any offset outside {0x00, 0x01, 0x02, 0x08}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; gates combinational `rdata` |
| unlock | input | 1 | Protection unit grants configuration writes |
| rdata | output | 8 | Read data |
| tick | output | 1 | One-cycle clock-enable pulse every N cycles |

## Verification
The divider is driven with each of the sixteen codes with the enable set, with the enable clear, and with the unused upper bits set. The spacing between pulses is measured each time, which separates the power-of-two branch, the non-binary branch, the reserved fallback and the bypass. Locked and unlocked writes go to every protected offset and to status, which separates gated storage from write-ignored storage. A switch from a slow ratio to a faster one checks that the counter restarts and does not finish its old count.

// File: rtl/clk_prescale_regs.sv
module clk_prescale_regs #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          unlock,
  output logic [DW-1:0] rdata,
  output logic          tick
);
  localparam logic [AW-1:0] OFS_CTL  = AW'(0);
  localparam logic [AW-1:0] OFS_PSC  = AW'(1);
  localparam logic [AW-1:0] OFS_STAT = AW'(2);
  localparam logic [AW-1:0] OFS_OSC  = AW'(8);
  localparam int RW = CW + 1;

  logic [DW-1:0] ctl_q, psc_q, stat_q, osc_q;
  logic [RW-1:0] ratio, ratio_q;
  logic [CW-1:0] cnt_q;

  wire wr_ok = wr_en & unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      psc_q  <= '0;
      stat_q <= '0;
      osc_q  <= '0;
    end else if (wr_ok) begin
      if (addr == OFS_CTL) ctl_q <= wdata;
      if (addr == OFS_OSC) osc_q <= wdata;
      if (addr == OFS_PSC) begin
        psc_q     <= wdata;
        stat_q[0] <= 1'b0;
      end
    end
  end

  function automatic logic [RW-1:0] div_of(input logic [3:0] code);
    case (code)
      4'd0:    div_of = RW'(2);
      4'd1:    div_of = RW'(4);
      4'd2:    div_of = RW'(8);
      4'd3:    div_of = RW'(16);
      4'd4:    div_of = RW'(32);
      4'd5:    div_of = RW'(64);
      4'd8:    div_of = RW'(6);
      4'd9:    div_of = RW'(10);
      4'd10:   div_of = RW'(12);
      4'd11:   div_of = RW'(24);
      4'd12:   div_of = RW'(48);
      default: div_of = RW'(2);
    endcase
  endfunction

  assign ratio = psc_q[0] ? div_of(psc_q[4:1]) : RW'(1);

  wire at_end = ({1'b0, cnt_q} == ratio - RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RW'(1);
    end else if (ratio != ratio_q) begin
      cnt_q   <= '0;
      ratio_q <= ratio;
    end else if (at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick = (cnt_q == '0);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_CTL:  rdata = ctl_q;
        OFS_PSC:  rdata = psc_q;
        OFS_STAT: rdata = stat_q & ~DW'(1);
        OFS_OSC:  rdata = osc_q;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/prescale_chk.sv
module prescale_chk #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic          unlock,
  input logic [DW-1:0] rdata,
  input logic          tick,
  input logic [DW-1:0] psc
);
  logic [7:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (tick) gap_q <= 8'd1;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
  end

  wire mapped = (addr == AW'(0)) || (addr == AW'(1)) || (addr == AW'(2)) || (addr == AW'(8));

  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock && addr == AW'(1)) |=> $stable(psc)); // R1
  AST_STATUS_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(2)) |-> (rdata[0] == 1'b0)); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |-> (rdata == '0)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0)); // R10
  AST_BYPASS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!psc[0] && !$past(psc[0])) |-> tick); // R3
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q <= 8'd64)); // R8
endmodule

bind clk_prescale_regs prescale_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .unlock(unlock), .rdata(rdata), .tick(tick), .psc(psc_q)
);

// File: tb/tb_clk_prescale_regs.sv
module tb_clk_prescale_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic       unlock = 1'b0;
  logic [7:0] rdata;
  logic       tick;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  clk_prescale_regs dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .unlock(unlock), .rdata(rdata), .tick(tick)
  );

  // {prescaler byte, expected period}
  localparam logic [15:0] VEC [18] = '{
    {8'h00, 8'd1},  {8'h01, 8'd2},  {8'h03, 8'd4},  {8'h05, 8'd8},
    {8'h07, 8'd16}, {8'h09, 8'd32}, {8'h0B, 8'd64}, {8'h0D, 8'd2},
    {8'h0F, 8'd2},  {8'h11, 8'd6},  {8'h13, 8'd10}, {8'h15, 8'd12},
    {8'h17, 8'd24}, {8'h19, 8'd48}, {8'h1B, 8'd2},  {8'h1D, 8'd2},
    {8'h1F, 8'd2},  {8'hE1, 8'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input logic u);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; unlock = u;
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic measure(output int p);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tick) break;
    end
    p = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      p++;
      if (tick) break;
    end
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    foreach (VEC[i]) begin end
    bus_read(4'h0, d); check(d == 8'h00, "R9", d, 0);
    bus_read(4'h1, d); check(d == 8'h00, "R9", d, 0);
    bus_read(4'h8, d); check(d == 8'h00, "R9", d, 0);
    measure(p); check(p == 1, "R9", p, 1);

    // table walk: R2 readback, R3/R4/R5/R6 period
    for (int i = 0; i < 18; i++) begin
      logic [7:0] v;
      logic [3:0] c;
      string tag;
      v = VEC[i][15:8];
      c = v[4:1];
      if (!v[0] || v[7:5] != 0) tag = "R3";
      else if (c <= 5) tag = "R4";
      else if (c >= 8 && c <= 12) tag = "R5";
      else tag = "R6";
      bus_write(4'h1, v, 1'b1);
      bus_read(4'h1, d); check(d == v, "R2", d, v);
      measure(p); check(p == int'(VEC[i][7:0]), tag, p, VEC[i][7:0]);
    end

    // R1 locked writes dropped
    bus_write(4'h1, 8'h0B, 1'b1);
    bus_write(4'h1, 8'h01, 1'b0);
    bus_read(4'h1, d); check(d == 8'h0B, "R1", d, 8'h0B);
    measure(p); check(p == 64, "R1", p, 64);
    bus_write(4'h0, 8'h5A, 1'b0);
    bus_read(4'h0, d); check(d == 8'h00, "R1", d, 0);
    bus_write(4'h8, 8'hA5, 1'b0);
    bus_read(4'h8, d); check(d == 8'h00, "R1", d, 0);

    // R2 unlocked writes to control and oscillator registers
    bus_write(4'h0, 8'h5A, 1'b1);
    bus_read(4'h0, d); check(d == 8'h5A, "R2", d, 8'h5A);
    bus_write(4'h8, 8'hA5, 1'b1);
    bus_read(4'h8, d); check(d == 8'hA5, "R2", d, 8'hA5);

    // R7 status ignores writes
    bus_write(4'h2, 8'hFF, 1'b1);
    bus_read(4'h2, d); check(d == 8'h00, "R7", d, 0);

    // R10 unmapped and idle reads
    bus_read(4'h3, d); check(d == 8'h00, "R10", d, 0);
    bus_read(4'hF, d); check(d == 8'h00, "R10", d, 0);
    @(negedge clk); addr = 4'h0; rd_en = 1'b0;
    #1 check(rdata == 8'h00, "R10", rdata, 0);

    // R8 restart on ratio change: from div64 to div16
    bus_write(4'h1, 8'h0B, 1'b1);
    repeat (20) @(negedge clk);
    bus_write(4'h1, 8'h07, 1'b1);
    @(negedge clk);
    check(tick == 1'b1, "R8", tick, 1);
    p = 0;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      if (tick) p++;
    end
    check(p == 0, "R8", p, 0);
    @(negedge clk);
    check(tick == 1'b1, "R8", tick, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule